// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a bank of already synchronized input pins and turns selected level conditions or transitions on them into interrupt requests. Software programs each pin as level-sensitive or edge-sensitive, picks the active level or edge direction, and can ask for detection on any transition. Detected edges are held in a sticky per-pin flag until software acknowledges them. A level condition tracks the live pin.

Every pin has an enable bit and a mask bit. Raw status shows what was detected before qualification. Masked status is raw status gated by enable and by the inverted mask. The OR of all masked bits drives a single registered request line to the parent interrupt controller.

Configuration uses a write-masked half-word scheme. Each 32-bit logical register occupies two word slots: pins 0 to 15 at the base offset and pins 16 to 31 at base+4. In a write, bits [31:16] are per-bit write enables for the data in bits [15:0], so one pin can be changed without a read-modify-write. The usual bring-up writes all ones to mask, acknowledge and enable. That leaves every pin enabled but masked, with no stale events.

Top module: `gpio_irq_unit`

## Requirements
- R1: After synchronous reset, every configuration bit (enable, mask, type, polarity, any-edge) is 0 and `irq_o` is 0, so masked status reads 0.
- R2: A write to offset O (low half, pins 0–15) or O+4 (high half, pins 16–31) changes bit k of that half only when wdata[16+k] is 1, and then loads wdata[k]. Offsets: enable 0x10, mask 0x18, type 0x20, polarity 0x28, any-edge 0x30.
- R3: A pin with type bit 0 is level-sensitive. Its raw bit is 1 while the pin equals its polarity bit (1 = active high, 0 = active low). It follows the pin with no latching.
- R4: A pin with type bit 1 is edge-sensitive. Polarity 1 detects rising edges and polarity 0 detects falling edges. A detected edge sets a raw bit that stays set after the pin returns.
- R5: When a pin's any-edge bit is 1 and its type is edge, both rising and falling edges are detected, whatever its polarity bit holds.
- R6: Masked status (read at 0x50/0x54) equals raw status (read at 0x58/0x5C) ANDed with enable and with the inverted mask. A mask bit of 1 or an enable bit of 0 removes the pin.
- R7: `irq_o` is the OR of masked status, registered. It changes on the clock edge after the masked status changes.
- R8: Writing the acknowledge slot (0x60/0x64) clears the held edge flag of each pin whose data and write-enable bits are both 1. Other pins keep their flags.
- R9: An edge detected in the same cycle as its own acknowledge leaves the flag set.
- R10: While a pin is level-sensitive its edge flag is held at 0, so returning it to edge mode shows no stale event.
- R11: `reg_rdata` returns, one clock after `reg_addr` is presented, the addressed half of the register as the low 16 bits, with bits [31:16] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Synchronized pin levels |
| reg_we | input | 1 | Write strobe for the register slot at `reg_addr` |
| reg_addr | input | 8 | Byte offset of the register slot |
| reg_wdata | input | 32 | Write data: [31:16] bit enables, [15:0] values |
| reg_rdata | output | 32 | Registered read data of the addressed half |
| irq_o | output | 1 | Combined interrupt request |

## Verification
An edge that appears on a pin is captured in its flag on the first rising clock edge. It raises `irq_o` on the second. A level condition raises `irq_o` on the first edge. Register writes and acknowledges act on the edge that samples the strobe, and a read shows the state at the edge that samples the address. The bench drives every input at the falling edge. It samples `irq_o` exactly one or two edges later as these rules dictate, and it also samples once before the due edge to confirm that the output is registered. Edge-flag checks go through raw and masked status reads so that the stickiness, acknowledge, coincidence and mode-switch cases are seen at the ports.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int unsigned REG_AW  = 8;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned HALF_W  = 16;

  localparam logic [REG_AW-1:0] OFS_ENABLE = 8'h10;
  localparam logic [REG_AW-1:0] OFS_MASK   = 8'h18;
  localparam logic [REG_AW-1:0] OFS_TYPE   = 8'h20;
  localparam logic [REG_AW-1:0] OFS_POL    = 8'h28;
  localparam logic [REG_AW-1:0] OFS_ANY    = 8'h30;
  localparam logic [REG_AW-1:0] OFS_STAT   = 8'h50;
  localparam logic [REG_AW-1:0] OFS_RAW    = 8'h58;
  localparam logic [REG_AW-1:0] OFS_ACK    = 8'h60;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ENABLE, SEL_MASK, SEL_TYPE, SEL_POL,
    SEL_ANY, SEL_STAT, SEL_RAW, SEL_ACK
  } slot_sel_e;

  // Bit 2 picks the half; the remaining bits name the logical register.
  function automatic slot_sel_e slot_decode(input logic [REG_AW-1:0] a);
    logic [REG_AW-1:0] base;
    base = a & ~(REG_AW'(4));
    case (base)
      OFS_ENABLE: slot_decode = SEL_ENABLE;
      OFS_MASK:   slot_decode = SEL_MASK;
      OFS_TYPE:   slot_decode = SEL_TYPE;
      OFS_POL:    slot_decode = SEL_POL;
      OFS_ANY:    slot_decode = SEL_ANY;
      OFS_STAT:   slot_decode = SEL_STAT;
      OFS_RAW:    slot_decode = SEL_RAW;
      OFS_ACK:    slot_decode = SEL_ACK;
      default:    slot_decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_irq_cfg.sv
`timescale 1ns/1ps
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  slot_sel_e            wr_sel,
  input  logic                 wr_hi,
  input  logic [BUS_W-1:0]     wr_data,
  output logic [NPINS-1:0]     en_o,
  output logic [NPINS-1:0]     mask_o,
  output logic [NPINS-1:0]     type_o,
  output logic [NPINS-1:0]     pol_o,
  output logic [NPINS-1:0]     any_o,
  output logic [NPINS-1:0]     ack_o
);
  logic [NPINS-1:0] bit_we;
  logic [NPINS-1:0] bit_val;

  // Map each pin onto its half-word lane and its write-enable bit.
  for (genvar i = 0; i < NPINS; i++) begin : g_lane
    localparam int unsigned POS = i % HALF_W;
    localparam bit          HI  = (i >= HALF_W);
    assign bit_we[i]  = wr_en && (wr_hi == HI) && wr_data[HALF_W+POS];
    assign bit_val[i] = wr_data[POS];
  end

  function automatic logic [NPINS-1:0] merge(input logic [NPINS-1:0] old_v,
                                             input logic [NPINS-1:0] we_v,
                                             input logic [NPINS-1:0] val_v);
    merge = (old_v & ~we_v) | (val_v & we_v);
  endfunction

  logic [NPINS-1:0] en_q, mask_q, type_q, pol_q, any_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
    end else begin
      case (wr_sel)
        SEL_ENABLE: en_q   <= merge(en_q,   bit_we, bit_val);
        SEL_MASK:   mask_q <= merge(mask_q, bit_we, bit_val);
        SEL_TYPE:   type_q <= merge(type_q, bit_we, bit_val);
        SEL_POL:    pol_q  <= merge(pol_q,  bit_we, bit_val);
        SEL_ANY:    any_q  <= merge(any_q,  bit_we, bit_val);
        default: ;
      endcase
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign type_o = type_q;
  assign pol_o  = pol_q;
  assign any_o  = any_q;
  assign ack_o  = (wr_sel == SEL_ACK) ? (bit_we & bit_val) : '0;
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] type_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] any_i,
  input  logic [NPINS-1:0] ack_i,
  output logic [NPINS-1:0] raw_o
);
  logic [NPINS-1:0] pin_q;
  logic [NPINS-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, hit, flag_d;
    always_comb begin
      rise = pin_i[i] & ~pin_q[i];
      fall = ~pin_i[i] & pin_q[i];
      if (any_i[i]) hit = rise | fall;
      else          hit = pol_i[i] ? rise : fall;
      // A new edge wins over a same-cycle acknowledge.
      flag_d = type_i[i] ? ((flag_q[i] & ~ack_i[i]) | hit) : 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d;
    end

    assign raw_o[i] = type_i[i] ? flag_q[i] : ~(pin_i[i] ^ pol_i[i]);
  end
endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32  // at most two half-word lanes (32)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  slot_sel_e        sel;
  logic             sel_hi;
  logic [NPINS-1:0] en_w, mask_w, type_w, pol_w, any_w, ack_w, raw_w, stat_w;

  assign sel    = slot_decode(reg_addr);
  assign sel_hi = reg_addr[2];

  gpio_irq_cfg #(.NPINS(NPINS)) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_we),
    .wr_sel  (sel),
    .wr_hi   (sel_hi),
    .wr_data (reg_wdata),
    .en_o    (en_w),
    .mask_o  (mask_w),
    .type_o  (type_w),
    .pol_o   (pol_w),
    .any_o   (any_w),
    .ack_o   (ack_w)
  );

  gpio_irq_detect #(.NPINS(NPINS)) det_i (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_i),
    .type_i (type_w),
    .pol_i  (pol_w),
    .any_i  (any_w),
    .ack_i  (ack_w),
    .raw_o  (raw_w)
  );

  assign stat_w = raw_w & en_w & ~mask_w;

  logic [BUS_W-1:0]  rd_full;
  logic [HALF_W-1:0] rd_half;

  always_comb begin
    rd_full = '0;
    case (sel)
      SEL_ENABLE: rd_full[NPINS-1:0] = en_w;
      SEL_MASK:   rd_full[NPINS-1:0] = mask_w;
      SEL_TYPE:   rd_full[NPINS-1:0] = type_w;
      SEL_POL:    rd_full[NPINS-1:0] = pol_w;
      SEL_ANY:    rd_full[NPINS-1:0] = any_w;
      SEL_STAT:   rd_full[NPINS-1:0] = stat_w;
      SEL_RAW:    rd_full[NPINS-1:0] = raw_w;
      default: ;
    endcase
    rd_half = sel_hi ? rd_full[BUS_W-1:HALF_W] : rd_full[HALF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      reg_rdata <= {{(BUS_W-HALF_W){1'b0}}, rd_half};
      irq_o     <= |stat_w;
    end
  end
endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [7:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             irq_o,
  input logic [NPINS-1:0] raw,
  input logic [NPINS-1:0] en,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] typ,
  input logic [NPINS-1:0] ack
);
  AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (en == '0 && mask == '0 && typ == '0 && !irq_o)); // R1

  AST_NO_ENABLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == OFS_TYPE && reg_wdata[31:16] == 16'h0) |=> $stable(typ)); // R2

  AST_EDGE_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((typ & $past(typ) & $past(raw) & ~$past(ack)) & ~raw) == '0); // R4

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(&mask) |-> !irq_o); // R6

  AST_IRQ_FROM_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(raw & en & ~mask))); // R7

  AST_STATUS_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    $past(|(raw & en & ~mask)) |-> irq_o); // R7
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NPINS(NPINS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_o     (irq_o),
  .raw       (raw_w),
  .en        (en_w),
  .mask      (mask_w),
  .typ       (type_w),
  .ack       (ack_w)
);

// File: tb/gpio_irq_unit_tb.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb_top;
  localparam int NPINS = 32;

  logic             clk = 1'b0;
  logic             rst;
  logic [NPINS-1:0] pin_i;
  logic             reg_we;
  logic [7:0]       reg_addr;
  logic [31:0]      reg_wdata;
  logic [31:0]      reg_rdata;
  logic             irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_unit #(.NPINS(NPINS)) dut_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rd(8'h10, d); check("R1 enable reset", d, 32'h0);
    rd(8'h24, d); check("R1 type hi reset", d, 32'h0);
    rd(8'h50, d); check("R1 status reset", d, 32'h0);
  endtask

  task automatic t_init();
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF); wr(8'h64, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
  endtask

  task automatic t_masked_write();
    logic [31:0] d;
    wr(8'h20, 32'h00FF_00AA);
    rd(8'h20, d); check("R2 partial low write", d, 32'h0000_00AA);
    wr(8'h20, 32'h0001_FFFF);
    rd(8'h20, d); check("R2 single enabled bit", d, 32'h0000_00AB);
    wr(8'h24, 32'h8000_8000);
    rd(8'h24, d); check("R11 high half read", d, 32'h0000_8000);
    wr(8'h20, 32'h0000_FFFF);
    rd(8'h20, d); check("R2 no enables ignored", d, 32'h0000_00AB);
    wr(8'h20, 32'hFFFF_0000); wr(8'h24, 32'hFFFF_0000);
    rd(8'h20, d); check("R2 cleared low", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(8'h28, 32'h0008_0008);
    wr(8'h18, 32'h0008_0000);
    tick();
    check("R3 inactive level", {31'b0, irq_o}, 32'h0);
    pin_i[3] = 1'b1;
    check("R7 not before edge", {31'b0, irq_o}, 32'h0);
    tick();
    check("R3 active high level", {31'b0, irq_o}, 32'h1);
    rd(8'h58, d); check("R3 raw bit3", d & 32'h8, 32'h8);
    pin_i[3] = 1'b0;
    tick();
    check("R3 level not latched", {31'b0, irq_o}, 32'h0);
    rd(8'h58, d); check("R3 active low bit4", d & 32'h18, 32'h10);
    wr(8'h18, 32'h0008_0008);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(8'h20, 32'h0060_0060);
    wr(8'h28, 32'h0020_0020);
    wr(8'h18, 32'h0020_0000);
    pin_i[5] = 1'b1;
    tick();
    check("R7 irq one edge behind flag", {31'b0, irq_o}, 32'h0);
    tick();
    check("R4 rising edge irq", {31'b0, irq_o}, 32'h1);
    pin_i[5] = 1'b0;
    tick(); tick();
    check("R4 sticky after pin returns", {31'b0, irq_o}, 32'h1);
    pin_i[6] = 1'b1;
    tick();
    rd(8'h58, d); check("R4 rising ignored for pol0", d & 32'h60, 32'h20);
    pin_i[6] = 1'b0;
    tick();
    rd(8'h58, d); check("R4 falling edge pol0", d & 32'h60, 32'h60);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    wr(8'h60, 32'h0020_0020);
    rd(8'h58, d); check("R8 only acked pin cleared", d & 32'h60, 32'h40);
    check("R8 irq drops after ack", {31'b0, irq_o}, 32'h0);
    wr(8'h60, 32'h0040_0000);
    rd(8'h58, d); check("R8 ack without enable ignored", d & 32'h40, 32'h40);
    wr(8'h60, 32'h0040_0040);
    rd(8'h58, d); check("R8 second ack", d & 32'h60, 32'h0);
  endtask

  task automatic t_any_edge();
    logic [31:0] d;
    wr(8'h20, 32'h0080_0080);
    wr(8'h28, 32'h0080_0080);
    wr(8'h30, 32'h0080_0080);
    pin_i[7] = 1'b1;
    tick();
    rd(8'h58, d); check("R5 rise caught", d & 32'h80, 32'h80);
    wr(8'h60, 32'h0080_0080);
    pin_i[7] = 1'b0;
    tick();
    rd(8'h58, d); check("R5 fall caught despite pol1", d & 32'h80, 32'h80);
  endtask

  task automatic t_status();
    logic [31:0] d;
    rd(8'h50, d); check("R6 masked pin hidden", d & 32'h80, 32'h0);
    check("R6 masked no irq", {31'b0, irq_o}, 32'h0);
    wr(8'h18, 32'h0080_0000);
    rd(8'h50, d); check("R6 unmasked visible", d & 32'h80, 32'h80);
    check("R7 irq from unmasked", {31'b0, irq_o}, 32'h1);
    wr(8'h10, 32'h0080_0000);
    rd(8'h50, d); check("R6 disabled hidden", d & 32'h80, 32'h0);
    check("R7 irq after disable", {31'b0, irq_o}, 32'h0);
    wr(8'h10, 32'h0080_0080);
    wr(8'h18, 32'h0080_0080);
    wr(8'h60, 32'h0080_0080);
  endtask

  task automatic t_coincident();
    logic [31:0] d;
    wr(8'h20, 32'h0100_0100);
    wr(8'h28, 32'h0100_0100);
    pin_i[8] = 1'b1; tick();
    pin_i[8] = 1'b0; tick();
    pin_i[8] = 1'b1;
    wr(8'h60, 32'h0100_0100);
    rd(8'h58, d); check("R9 edge beats ack", d & 32'h100, 32'h100);
    wr(8'h60, 32'h0100_0100);
    rd(8'h58, d); check("R8 plain ack", d & 32'h100, 32'h0);
  endtask

  task automatic t_switch();
    logic [31:0] d;
    pin_i[8] = 1'b0; tick();
    pin_i[8] = 1'b1; tick();
    rd(8'h58, d); check("R4 flag before switch", d & 32'h100, 32'h100);
    wr(8'h20, 32'h0100_0000);
    pin_i[8] = 1'b0; tick();
    rd(8'h58, d); check("R10 level follows pin", d & 32'h100, 32'h0);
    wr(8'h20, 32'h0100_0100);
    rd(8'h58, d); check("R10 no stale flag", d & 32'h100, 32'h0);
  endtask

  initial begin
    rst = 1'b1; pin_i = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_init();
    t_masked_write();
    t_level();
    t_edge();
    t_ack();
    t_any_edge();
    t_status();
    t_coincident();
    t_switch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule